// File: doc/BRIEF.md
# Descriptor-Fetching DMA Channel

This block is one DMA channel that loads its own transfer setup from memory. Software places a four-word descriptor in memory, writes the descriptor's byte address into the channel's pointer register, and then writes the start command. The channel reads the four words over a request/acknowledge read port, in the order source address, destination address, length in bytes, control word, and keeps them in staging registers. It then copies them, unchecked, into its working registers.

A copy loop then moves whole words from the source to the destination in bursts. Every beat of a burst is read into a local buffer before any beat of that burst is written. The burst size comes from the control word, and the last burst is cut short when fewer words remain. When the last word has been written, the channel holds its interrupt high until software writes 1 to the clear bit of the status register.

The register port has three word offsets. Offset 0 is the descriptor pointer, which can be read and written. Offset 1 is the command register, where writing bit 0 as 1 requests a start. Offset 2 is the status register: bit 0 is busy, bit 1 is the interrupt, and writing 1 to bit 1 clears the interrupt. Reads from any other offset return 0.

Top module: `desc_dma_channel`

## Requirements
- R1: After reset the status register reads 0, the pointer reads 0, irq is low, and neither memRdReq nor memWrReq is asserted.
- R2: After a start from idle, the first four reads the channel issues are at P, P+4, P+8 and P+12 in that order, where P is the pointer value at the time of the start. Those reads return source, destination, length and control.
- R3: The channel copies floor(length/4) words from ascending source addresses to ascending destination addresses. The two low bits of the length are ignored, and no word past the end of the destination range is written.
- R4: Control bits [1:0] select the burst size: 0 gives 1 beat, 1 gives 4, 2 gives 8 and 3 gives 16. Each burst reads min(remaining, size) words before it writes any, and the read and write ports are never requested together.
- R5: The final burst is shortened to the number of words still remaining.
- R6: A length below 4 bytes produces no source read and no destination write, and the channel goes straight to completion with irq raised.
- R7: At completion, irq and status bit 1 go high and stay high until a write of 1 to status bit 1. A status write with bit 1 at 0 has no effect.
- R8: Status bit 0 is 1 from the cycle after an accepted start until the interrupt is cleared. A start request made in that window, including while the interrupt is pending, is ignored and never acted on later.
- R9: Control bits above [1:0] have no effect on the transfer.
- R10: A read or write request keeps its address, and a write request keeps its data, stable until the request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational on regAddr |
| memRdReq | output | 1 | Memory read request |
| memRdAddr | output | 32 | Memory read byte address |
| memRdAck | input | 1 | Read acknowledge; memRdData is valid in the same cycle |
| memRdData | input | 32 | Memory read data |
| memWrReq | output | 1 | Memory write request |
| memWrAddr | output | 32 | Memory write byte address |
| memWrData | output | 32 | Memory write data |
| memWrAck | input | 1 | Write acknowledge |
| irq | output | 1 | Completion interrupt |

## Verification
The properties assume the responder asserts memRdAck or memWrAck only in a cycle where the matching request is high, and that read data is valid in the acknowledge cycle. They also assume the descriptor, source and destination regions do not overlap, and that no descriptor word changes while it is being fetched. The bench memory model acknowledges only requests that are pending, either on every cycle or on every other cycle. It places descriptors, sources and destinations in disjoint address ranges, and it rewrites a descriptor only while the channel is idle.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  localparam int ADDR_W         = 32;
  localparam int DATA_W         = 32;
  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int WORD_SHIFT     = $clog2(BYTES_PER_WORD);
  localparam int LEN_WORDS_W    = DATA_W - WORD_SHIFT;
  localparam int MAX_BURST      = 16;
  localparam int BEAT_IDX_W     = $clog2(MAX_BURST);
  localparam int BURST_LEN_W    = $clog2(MAX_BURST + 1);
  localparam int DESC_WORDS     = 4;
  localparam int DESC_IDX_W     = $clog2(DESC_WORDS);

  localparam logic [1:0] REG_PTR  = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_READ_BURST,
    ST_WRITE_BURST,
    ST_DONE
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fetchSel;
    logic fetchInit;
    logic fetchBeat;
    logic loadRegs;
    logic burstBegin;
    logic readBeat;
    logic writeStart;
    logic writeBeat;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic fetchLast;
    logic lenZero;
    logic readLast;
    logic writeLast;
    logic noneLeft;
  } dpStat_t;

  function automatic logic [BURST_LEN_W-1:0] beatsOf(input logic [1:0] code);
    case (code)
      2'd0:    beatsOf = BURST_LEN_W'(1);
      2'd1:    beatsOf = BURST_LEN_W'(4);
      2'd2:    beatsOf = BURST_LEN_W'(8);
      default: beatsOf = BURST_LEN_W'(MAX_BURST);
    endcase
  endfunction
endpackage

// File: rtl/desc_dma_ctrl.sv
module desc_dma_ctrl
  import desc_dma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    irqClear,
  input  logic    memRdAck,
  input  logic    memWrAck,
  input  dpStat_t dpStat,
  output dpCmd_t  dpCmd,
  output logic    memRdReq,
  output logic    memWrReq,
  output logic    busy,
  output logic    irq
);
  chanState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    dpCmd     = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          dpCmd.fetchInit = 1'b1;
          stateNext       = ST_FETCH;
        end
      end
      ST_FETCH: begin
        dpCmd.fetchSel = 1'b1;
        if (memRdAck) begin
          dpCmd.fetchBeat = 1'b1;
          if (dpStat.fetchLast) stateNext = ST_LOAD;
        end
      end
      ST_LOAD: begin
        dpCmd.loadRegs   = 1'b1;
        dpCmd.burstBegin = 1'b1;
        stateNext        = dpStat.lenZero ? ST_DONE : ST_READ_BURST;
      end
      ST_READ_BURST: begin
        if (memRdAck) begin
          dpCmd.readBeat = 1'b1;
          if (dpStat.readLast) begin
            dpCmd.writeStart = 1'b1;
            stateNext        = ST_WRITE_BURST;
          end
        end
      end
      ST_WRITE_BURST: begin
        if (memWrAck) begin
          dpCmd.writeBeat = 1'b1;
          if (dpStat.writeLast) begin
            if (dpStat.noneLeft) begin
              stateNext = ST_DONE;
            end else begin
              dpCmd.burstBegin = 1'b1;
              stateNext        = ST_READ_BURST;
            end
          end
        end
      end
      ST_DONE: begin
        if (irqClear) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memRdReq = (state == ST_FETCH) || (state == ST_READ_BURST);
  assign memWrReq = (state == ST_WRITE_BURST);
  assign busy     = (state != ST_IDLE);
  assign irq      = (state == ST_DONE);
endmodule

// File: rtl/desc_dma_datapath.sv
module desc_dma_datapath
  import desc_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrWrEn,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  dpCmd_t            dpCmd,
  input  logic [DATA_W-1:0] memRdData,
  output dpStat_t           dpStat,
  output logic [ADDR_W-1:0] descPtr,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  logic [ADDR_W-1:0]      fetchBase;
  logic [DESC_IDX_W-1:0]  fetchIdx;
  logic [ADDR_W-1:0]      stSrc, stDst;
  logic [LEN_WORDS_W-1:0] stLen;
  logic [1:0]             stCode;
  logic [ADDR_W-1:0]      srcAddr, dstAddr;
  logic [LEN_WORDS_W-1:0] remWords;
  logic [1:0]             burstCode;
  logic [BURST_LEN_W-1:0] burstLen, burstLenNext, beatsSel, beatNext;
  logic [BEAT_IDX_W-1:0]  beatIdx;
  logic [LEN_WORDS_W-1:0] remSel;
  logic [1:0]             codeSel;
  logic [DATA_W-1:0]      burstBuf [MAX_BURST];

  always_ff @(posedge clk) begin
    if (!rstN) descPtr <= '0;
    else if (ptrWrEn) descPtr <= ptrWrData;
  end

  // descriptor fetch into staging registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchBase <= '0;
      fetchIdx  <= '0;
      stSrc     <= '0;
      stDst     <= '0;
      stLen     <= '0;
      stCode    <= '0;
    end else if (dpCmd.fetchInit) begin
      fetchBase <= descPtr;
      fetchIdx  <= '0;
    end else if (dpCmd.fetchBeat) begin
      case (fetchIdx)
        DESC_IDX_W'(0): stSrc  <= memRdData;
        DESC_IDX_W'(1): stDst  <= memRdData;
        DESC_IDX_W'(2): stLen  <= memRdData[DATA_W-1:WORD_SHIFT];
        default:        stCode <= memRdData[1:0];
      endcase
      fetchIdx <= fetchIdx + DESC_IDX_W'(1);
    end
  end

  // working registers of the copy loop
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr   <= '0;
      dstAddr   <= '0;
      remWords  <= '0;
      burstCode <= '0;
    end else if (dpCmd.loadRegs) begin
      srcAddr   <= stSrc;
      dstAddr   <= stDst;
      remWords  <= stLen;
      burstCode <= stCode;
    end else begin
      if (dpCmd.readBeat) begin
        srcAddr  <= srcAddr + ADDR_W'(BYTES_PER_WORD);
        remWords <= remWords - LEN_WORDS_W'(1);
      end
      if (dpCmd.writeBeat) dstAddr <= dstAddr + ADDR_W'(BYTES_PER_WORD);
    end
  end

  // burst sizing: shortened when fewer words remain
  assign remSel   = dpCmd.loadRegs ? stLen  : remWords;
  assign codeSel  = dpCmd.loadRegs ? stCode : burstCode;
  assign beatsSel = beatsOf(codeSel);
  assign burstLenNext = (remSel < LEN_WORDS_W'(beatsSel)) ? BURST_LEN_W'(remSel) : beatsSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstLen <= '0;
      beatIdx  <= '0;
    end else begin
      if (dpCmd.burstBegin) burstLen <= burstLenNext;
      if (dpCmd.burstBegin || dpCmd.writeStart) beatIdx <= '0;
      else if (dpCmd.readBeat || dpCmd.writeBeat) beatIdx <= beatIdx + BEAT_IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (dpCmd.readBeat) burstBuf[beatIdx] <= memRdData;
  end

  assign beatNext = BURST_LEN_W'(beatIdx) + BURST_LEN_W'(1);

  assign dpStat.fetchLast = (fetchIdx == DESC_IDX_W'(DESC_WORDS - 1));
  assign dpStat.lenZero   = (stLen == '0);
  assign dpStat.readLast  = (beatNext == burstLen);
  assign dpStat.writeLast = (beatNext == burstLen);
  assign dpStat.noneLeft  = (remWords == '0);

  assign memRdAddr = dpCmd.fetchSel ? fetchBase + (ADDR_W'(fetchIdx) << WORD_SHIFT) : srcAddr;
  assign memWrAddr = dstAddr;
  assign memWrData = burstBuf[beatIdx];
endmodule

// File: rtl/desc_dma_channel.sv
module desc_dma_channel
  import desc_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdAck,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrReq,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrAck,
  output logic              irq
);
  dpCmd_t            dpCmd;
  dpStat_t           dpStat;
  logic              busy;
  logic              startReq, irqClear, ptrWrEn;
  logic [ADDR_W-1:0] descPtr;

  assign ptrWrEn  = regWrEn && (regAddr == REG_PTR);
  assign startReq = regWrEn && (regAddr == REG_CMD)  && regWrData[0];
  assign irqClear = regWrEn && (regAddr == REG_STAT) && regWrData[1];

  desc_dma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .irqClear (irqClear),
    .memRdAck (memRdAck),
    .memWrAck (memWrAck),
    .dpStat   (dpStat),
    .dpCmd    (dpCmd),
    .memRdReq (memRdReq),
    .memWrReq (memWrReq),
    .busy     (busy),
    .irq      (irq)
  );

  desc_dma_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ptrWrEn   (ptrWrEn),
    .ptrWrData (regWrData),
    .dpCmd     (dpCmd),
    .memRdData (memRdData),
    .dpStat    (dpStat),
    .descPtr   (descPtr),
    .memRdAddr (memRdAddr),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData)
  );

  always_comb begin
    case (regAddr)
      REG_PTR:  regRdData = descPtr;
      REG_STAT: regRdData = DATA_W'({irq, busy});
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/desc_dma_checker.sv
module desc_dma_checker
  import desc_dma_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memRdReq,
  input logic              memRdAck,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memWrReq,
  input logic              memWrAck,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              irq,
  input logic              busy,
  input logic              irqClear,
  input logic              startReq
);
  localparam int RUN_LIMIT = MAX_BURST + DESC_WORDS;
  localparam int RUN_W     = $clog2(RUN_LIMIT + 2);

  logic [RUN_W-1:0] readRun;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) readRun <= '0;
    else if (memWrReq && memWrAck) readRun <= '0;
    else if (memRdReq && memRdAck && readRun != '1) readRun <= readRun + RUN_W'(1);
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdAck |=> memRdReq && $stable(memRdAddr));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq && !memWrAck |=> memWrReq && $stable(memWrAddr) && $stable(memWrData));

  assert_one_port_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdReq && memWrReq));

  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    readRun <= RUN_W'(RUN_LIMIT));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memRdReq && !memWrReq);

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq && !irqClear |=> irq);

  assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(irqClear));

  assert_start_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));
endmodule

bind desc_dma_channel desc_dma_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memRdReq  (memRdReq),
  .memRdAck  (memRdAck),
  .memRdAddr (memRdAddr),
  .memWrReq  (memWrReq),
  .memWrAck  (memWrAck),
  .memWrAddr (memWrAddr),
  .memWrData (memWrData),
  .irq       (irq),
  .busy      (busy),
  .irqClear  (irqClear),
  .startReq  (startReq)
);

// File: tb/desc_dma_channel_bench.sv
`timescale 1ns/1ps
module desc_dma_channel_bench;
  localparam int MEM_WORDS = 2048;
  localparam int NVEC = 6;
  // length in bytes, control word, expected first and last read-run lengths
  localparam logic [31:0] V_LEN   [NVEC] = '{32'd16, 32'd40, 32'd100, 32'd12, 32'd68, 32'd22};
  localparam logic [31:0] V_CTRL  [NVEC] = '{32'd1, 32'd3, 32'd2, 32'd0, 32'd3, 32'hFFFF_FFF1};
  localparam int          V_FIRST [NVEC] = '{4, 10, 8, 1, 16, 4};
  localparam int          V_LAST  [NVEC] = '{4, 10, 1, 1, 1, 1};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        memRdReq, memRdAck, memWrReq, memWrAck, irq;
  logic [31:0] memRdAddr, memRdData, memWrAddr, memWrData;

  desc_dma_channel u_desc_dma_channel (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdAck(memRdAck), .memRdData(memRdData),
    .memWrReq(memWrReq), .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrAck(memWrAck),
    .irq(irq)
  );

  // memory model and monitor: the only process touching these variables
  logic [31:0] mem [MEM_WORDS];
  logic        memInit = 1'b0;
  logic        toggle = 1'b0;
  logic        stallOn;
  logic        hwEn;
  logic [31:0] hwAddr, hwData;
  int transfers = 0, descErr = 0, srcReads = 0, writes = 0;
  int curDescIdx = 4, runLen = 0, firstRun = 0;
  logic [31:0] curDescBase = 0;
  logic lastWrite = 1'b1, firstSeen = 1'b0;

  function automatic logic [31:0] initVal(input logic [31:0] byteAddr);
    return 32'hC0DE_0000 | (byteAddr >> 2);
  endfunction

  always @(negedge clk) begin
    if (!memInit) begin
      for (int k = 0; k < MEM_WORDS; k++) mem[k] = initVal(k * 4);
      memInit = 1'b1;
    end
    if (hwEn) mem[hwAddr[12:2]] = hwData;
    toggle = ~toggle;
    memRdAck = 1'b0;
    memWrAck = 1'b0;
    memRdData = 32'h0;
    if (memRdReq && !(stallOn && toggle)) begin
      memRdAck  = 1'b1;
      memRdData = mem[memRdAddr[12:2]];
      if (memRdAddr < 32'h100) begin
        if (curDescIdx == 4) begin
          transfers++;
          curDescBase = memRdAddr;
          curDescIdx = 0;
          runLen = 0;
          firstSeen = 1'b0;
          lastWrite = 1'b1;
        end
        if (memRdAddr != curDescBase + 4 * curDescIdx) descErr++;
        curDescIdx++;
      end else begin
        srcReads++;
        if (lastWrite) begin runLen = 1; lastWrite = 1'b0; end
        else runLen++;
      end
    end
    if (memWrReq && !(stallOn && toggle)) begin
      memWrAck = 1'b1;
      mem[memWrAddr[12:2]] = memWrData;
      writes++;
      if (!firstSeen) begin firstRun = runLen; firstSeen = 1'b1; end
      lastWrite = 1'b1;
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    hwEn = 1'b1; hwAddr = a; hwData = d;
    @(negedge clk); #1;
    hwEn = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic putDesc(input logic [31:0] p, input logic [31:0] s, input logic [31:0] dd,
                         input logic [31:0] len, input logic [31:0] ctl);
    hostWrite(p, s);
    hostWrite(p + 4, dd);
    hostWrite(p + 8, len);
    hostWrite(p + 12, ctl);
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    check(irq === 1'b1, req, "completion irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic runOne(input logic [31:0] p, input logic [31:0] s, input logic [31:0] dd,
                        input logic [31:0] len, input logic [31:0] ctl,
                        input int expFirst, input int expLast);
    int t0, w0, r0, e0, words, bad;
    logic [31:0] st, badAct, badExp;
    words = int'(len >> 2);
    putDesc(p, s, dd, len, ctl);
    t0 = transfers; w0 = writes; r0 = srcReads; e0 = descErr;
    regWrite(2'd0, p);
    regWrite(2'd1, 32'h1);
    regRead(2'd2, st);
    check(st[0] === 1'b1, "R8", "busy after start", st, 32'h1);
    waitIrq("R7");
    @(negedge clk);
    check(transfers - t0 == 1, "R2", "descriptor fetches", transfers - t0, 1);
    check(descErr == e0 && curDescBase == p, "R2", "descriptor read order/base", curDescBase, p);
    check(srcReads - r0 == words, "R3", "source reads", srcReads - r0, words);
    check(writes - w0 == words, "R3", "destination writes", writes - w0, words);
    bad = 0; badAct = 0; badExp = 0;
    for (int k = 0; k < words; k++) begin
      if (mem[(dd >> 2) + k] !== initVal(s + 4 * k)) begin
        if (bad == 0) begin badAct = mem[(dd >> 2) + k]; badExp = initVal(s + 4 * k); end
        bad++;
      end
    end
    check(bad == 0, "R3", "copied data", badAct, badExp);
    check(mem[(dd >> 2) + words] === initVal(dd + 4 * words), "R3", "word past end untouched",
          mem[(dd >> 2) + words], initVal(dd + 4 * words));
    if (words > 0) begin
      check(firstRun == expFirst, (ctl[31:2] != 0) ? "R9" : "R4", "first burst length",
            firstRun, expFirst);
      check(runLen == expLast, "R5", "final burst length", runLen, expLast);
    end
    regRead(2'd2, st);
    check(st === 32'h3, "R7", "status at completion", st, 32'h3);
    regWrite(2'd2, 32'h2);
    regRead(2'd2, st);
    check(st === 32'h0 && irq === 1'b0, "R7", "status after clear", st, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] st;
    int t0, w0, r0;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 2'd0; regWrData = 32'h0;
    hwEn = 1'b0; hwAddr = 32'h0; hwData = 32'h0; stallOn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    regRead(2'd2, st);
    check(st === 32'h0, "R1", "status after reset", st, 32'h0);
    regRead(2'd0, st);
    check(st === 32'h0, "R1", "pointer after reset", st, 32'h0);
    check(irq === 1'b0, "R1", "irq after reset", {31'b0, irq}, 32'h0);
    check(!memRdReq && !memWrReq, "R1", "no requests after reset",
          {30'b0, memRdReq, memWrReq}, 32'h0);

    // table of transfers, alternating stall pattern
    for (int i = 0; i < NVEC; i++) begin
      stallOn = i[0];
      runOne(i * 16, 32'h400 + i * 32'h100, 32'h1000 + i * 32'h100,
             V_LEN[i], V_CTRL[i], V_FIRST[i], V_LAST[i]);
    end

    // R8: start ignored while busy and while interrupt pending
    stallOn = 1'b1;
    putDesc(32'h80, 32'hA00, 32'h1800, 32'd64, 32'd2);
    putDesc(32'h90, 32'hB00, 32'h1900, 32'd3, 32'd1);
    t0 = transfers; w0 = writes; r0 = srcReads;
    regWrite(2'd0, 32'h80);
    regWrite(2'd1, 32'h1);
    regWrite(2'd0, 32'h90);
    regWrite(2'd1, 32'h1);
    waitIrq("R8");
    @(negedge clk);
    check(transfers - t0 == 1 && curDescBase == 32'h80, "R8", "start while busy ignored",
          transfers - t0, 1);
    check(writes - w0 == 16, "R8", "busy transfer word count", writes - w0, 16);
    regRead(2'd0, st);
    check(st === 32'h90, "R8", "pointer written while busy", st, 32'h90);
    regWrite(2'd1, 32'h1);
    repeat (6) @(negedge clk);
    regRead(2'd2, st);
    check(st === 32'h3 && transfers - t0 == 1, "R8", "start while done ignored", st, 32'h3);
    regWrite(2'd2, 32'h1);
    regRead(2'd2, st);
    check(st === 32'h3, "R7", "status write without bit1 keeps irq", st, 32'h3);
    regWrite(2'd2, 32'h2);
    repeat (10) @(negedge clk);
    regRead(2'd2, st);
    check(st === 32'h0 && transfers - t0 == 1 && !memRdReq, "R8", "no deferred start",
          st, 32'h0);

    // R6: length below one word
    t0 = transfers; w0 = writes; r0 = srcReads;
    regWrite(2'd1, 32'h1);
    waitIrq("R6");
    @(negedge clk);
    check(transfers - t0 == 1 && curDescBase == 32'h90, "R6", "short descriptor fetched",
          curDescBase, 32'h90);
    check(srcReads == r0 && writes == w0, "R6", "no data moved", writes - w0, 0);
    regWrite(2'd2, 32'h2);
    regRead(2'd2, st);
    check(st === 32'h0, "R6", "cleared after short transfer", st, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule